// File: doc/BRIEF.md
# Keyboard Controller Power-Down Sequencer

This block holds an embedded keyboard controller core in one of two sleep depths and brings it back to life. The instruction decoder supplies single-cycle strobes for the "halt" and "stop" instructions. The host side supplies a strobe each time it deposits a byte into the controller's input data buffer. The sequencer turns these into three clock-enable levels, one each for the CPU core clock, the timer/interrupt clock and the oscillator. It also produces one-cycle resume pulses that tell the core how to continue.

The shallow sleep depth, entered by a halt, gates only the CPU core. Timers and interrupt logic keep running. The deep depth, entered by a stop, turns the oscillator off, so every controller clock stops. A host byte write wakes either depth. After a deep sleep, the oscillator is first given a stabilisation interval of `STAB_CYCLES` clock cycles, and only then is the core released. When the core resumes, it either vectors to the buffer-full interrupt routine or carries on at the following instruction, depending on the interrupt enable. Reset from any state forces a full restart at program address zero.

Top module: `kbc_sleep_seq`

## Requirements
- R1: While `rst_n` is low, and up to the first rising clock edge after it goes high, `restart` is 1, `resume_vec` and `resume_next` are 0, and all three enables are 1. After that edge, `restart` is 0.
- R2: In the running state, a `halt_stb` without `stop_stb` gives, from the next cycle on, `cpu_clk_en`=0 while `tmr_clk_en`=1 and `osc_en`=1.
- R3: In the running state, `stop_stb` gives all three enables 0 from the next cycle on. This also holds when `halt_stb` is high in the same cycle, because stop takes priority.
- R4: Outside the running state, `halt_stb` and `stop_stb` have no effect on any output.
- R5: A `host_wr` during shallow sleep returns all enables to 1 in the next cycle, with a one-cycle pulse. The pulse is on `resume_vec` if `ibf_ie` was 1 at that edge, otherwise on `resume_next`.
- R6: A `host_wr` during deep sleep sets `osc_en`=1 in the next cycle. `cpu_clk_en` and `tmr_clk_en` stay 0 for exactly `STAB_CYCLES` cycles after the wake edge. Then all enables go to 1 together with one resume pulse, chosen by `ibf_ie` at the last edge of the wait.
- R7: Further `host_wr` strobes during the oscillator wait neither shorten nor lengthen it, and they add no extra resume pulse.
- R8: Driving `rst_n` low in any state returns the block to the running state with the restart behaviour of R1.
- R9: At most one of `resume_vec`, `resume_next` and `restart` is high in any cycle. Each resume pulse lasts a single cycle.
- R10: A `host_wr` in the running state produces no resume pulse and changes no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the reset wake source |
| halt_stb | input | 1 | Decoded halt instruction, one cycle |
| stop_stb | input | 1 | Decoded stop instruction, one cycle |
| host_wr | input | 1 | Host wrote a byte into the input data buffer |
| ibf_ie | input | 1 | Buffer-full interrupt enable |
| cpu_clk_en | output | 1 | Enable for the CPU core clock |
| tmr_clk_en | output | 1 | Enable for the timer and interrupt clock |
| osc_en | output | 1 | Oscillator driver enable |
| resume_vec | output | 1 | Pulse: resume by calling the buffer-full interrupt routine |
| resume_next | output | 1 | Pulse: resume at the following instruction |
| restart | output | 1 | Restart from program address zero |

## Verification
The assertions assume that `halt_stb`, `stop_stb` and `host_wr` are synchronous to `clk`, and that the clock keeps running while the oscillator enable is low. In silicon the clock would stop. Here the sequencer is taken to sit on a free-running always-on clock, so that it can count the stabilisation interval. The random stimulus changes inputs only on falling edges. It raises any mix of strobes in any state, including strobes that collide with each other and writes repeated during the wait. It also pulses reset at random, and a bench model tracks the expected enables and pulses cycle by cycle.

// File: rtl/kbc_sleep_pkg.sv
package kbc_sleep_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SOFT = 2'd1,
        ST_HARD = 2'd2,
        ST_OSCW = 2'd3
    } pd_state_e;

    typedef struct packed {
        pd_state_e st;
        logic      vec;
        logic      nxt;
        logic      rst;
    } seq_regs_t;

endpackage

// File: rtl/kbc_stab_timer.sv
module kbc_stab_timer #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)            cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);

    // R6: while waiting and not yet done, the count advances by one each cycle
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6: an idle timer always starts the next wait from zero
    p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/kbc_sleep_fsm.sv
module kbc_sleep_fsm
    import kbc_sleep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_stb,
    input  logic      stop_stb,
    input  logic      host_wr,
    input  logic      ibf_ie,
    input  logic      wait_done,
    output pd_state_e state,
    output logic      vec,
    output logic      nxt,
    output logic      rst_pulse
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vec = 1'b0;
        r_d.nxt = 1'b0;
        r_d.rst = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (stop_stb)      r_d.st = ST_HARD;
                else if (halt_stb) r_d.st = ST_SOFT;
            end
            ST_SOFT: begin
                if (host_wr) begin
                    r_d.st  = ST_RUN;
                    r_d.vec = ibf_ie;
                    r_d.nxt = !ibf_ie;
                end
            end
            ST_HARD: begin
                if (host_wr) r_d.st = ST_OSCW;
            end
            ST_OSCW: begin
                if (wait_done) begin
                    r_d.st  = ST_RUN;
                    r_d.vec = ibf_ie;
                    r_d.nxt = !ibf_ie;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_RUN;
            r_q.vec <= 1'b0;
            r_q.nxt <= 1'b0;
            r_q.rst <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.st;
    assign vec       = r_q.vec;
    assign nxt       = r_q.nxt;
    assign rst_pulse = r_q.rst;

    // R5: a host write in shallow sleep always yields a resume pulse
    p_soft_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SOFT && host_wr) |=> (vec || nxt));

    // R6: the oscillator wait persists until the timer reports done
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OSCW && !wait_done) |=> (r_q.st == ST_OSCW));

    // R4: instruction strobes leave a sleeping state untouched without a host write
    p_sleep_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_SOFT || r_q.st == ST_HARD) && !host_wr) |=> $stable(r_q.st));

endmodule

// File: rtl/kbc_clk_en_dec.sv
module kbc_clk_en_dec
    import kbc_sleep_pkg::*;
(
    input  pd_state_e state,
    output logic      cpu_en,
    output logic      tmr_en,
    output logic      osc_en
);
    always_comb begin
        unique case (state)
            ST_RUN:  {cpu_en, tmr_en, osc_en} = 3'b111;
            ST_SOFT: {cpu_en, tmr_en, osc_en} = 3'b011;
            ST_HARD: {cpu_en, tmr_en, osc_en} = 3'b000;
            ST_OSCW: {cpu_en, tmr_en, osc_en} = 3'b001;
            default: {cpu_en, tmr_en, osc_en} = 3'b111;
        endcase
    end
endmodule

// File: rtl/kbc_sleep_seq.sv
module kbc_sleep_seq
    import kbc_sleep_pkg::*;
#(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_stb,
    input  logic stop_stb,
    input  logic host_wr,
    input  logic ibf_ie,
    output logic cpu_clk_en,
    output logic tmr_clk_en,
    output logic osc_en,
    output logic resume_vec,
    output logic resume_next,
    output logic restart
);
    pd_state_e state;
    logic      wait_done;

    kbc_sleep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_stb  (halt_stb),
        .stop_stb  (stop_stb),
        .host_wr   (host_wr),
        .ibf_ie    (ibf_ie),
        .wait_done (wait_done),
        .state     (state),
        .vec       (resume_vec),
        .nxt       (resume_next),
        .rst_pulse (restart)
    );

    kbc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_OSCW),
        .done  (wait_done)
    );

    kbc_clk_en_dec u_dec (
        .state  (state),
        .cpu_en (cpu_clk_en),
        .tmr_en (tmr_clk_en),
        .osc_en (osc_en)
    );

    // R9: resume and restart indications never overlap
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_vec, resume_next, restart}));

    // R2: halt from the running state gates only the core clock
    p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && halt_stb && !stop_stb) |=> (!cpu_clk_en && tmr_clk_en && osc_en));

    // R3: stop from the running state shuts the oscillator down
    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && stop_stb) |=> (!osc_en && !tmr_clk_en && !cpu_clk_en));

    // R10: a host write while running yields no resume pulse
    p_run_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && host_wr && !halt_stb && !stop_stb) |=> (!resume_vec && !resume_next && cpu_clk_en));

    // R9: a resume pulse is a single cycle
    p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_vec || resume_next) |=> !(resume_vec || resume_next));

endmodule

// File: tb/kbc_sleep_seq_test.sv
module kbc_sleep_seq_test;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_stb = 1'b0, stop_stb = 1'b0, host_wr = 1'b0, ibf_ie = 1'b0;
    logic cpu_clk_en, tmr_clk_en, osc_en, resume_vec, resume_next, restart;

    always #5 clk = ~clk;

    kbc_sleep_seq #(.STAB_CYCLES(N)) uut (
        .clk(clk), .rst_n(rst_n), .halt_stb(halt_stb), .stop_stb(stop_stb),
        .host_wr(host_wr), .ibf_ie(ibf_ie), .cpu_clk_en(cpu_clk_en),
        .tmr_clk_en(tmr_clk_en), .osc_en(osc_en), .resume_vec(resume_vec),
        .resume_next(resume_next), .restart(restart)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model: 0 run, 1 shallow, 2 deep, 3 oscillator wait
    int m_st = 0;
    int m_cnt = 0;
    bit m_vec = 0, m_nxt = 0, m_rst = 1;

    function automatic logic [2:0] en_of(int st);
        case (st)
            0: return 3'b111;
            1: return 3'b011;
            2: return 3'b000;
            default: return 3'b001;
        endcase
    endfunction

    function automatic string req_for(int st, bit r, bit h, bit s, bit w);
        if (!r) return "R8";
        case (st)
            0: return s ? "R3" : (h ? "R2" : (w ? "R10" : "R9"));
            1: return w ? "R5" : "R4";
            2: return w ? "R6" : "R4";
            default: return w ? "R7" : "R6";
        endcase
    endfunction

    function automatic logic [5:0] expected();
        return {en_of(m_st), m_vec, m_nxt, m_rst};
    endfunction

    task automatic compare(string req);
        logic [5:0] act, exp;
        act = {cpu_clk_en, tmr_clk_en, osc_en, resume_vec, resume_next, restart};
        exp = expected();
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {cpu,tmr,osc,vec,nxt,rst} actual=%b expected=%b", req, act, exp);
        end
        n_checks++;
        if ($countones(act[2:0]) > 1) begin
            n_fail++;
            $display("FAIL R9: pulses overlap actual=%b expected at most one", act[2:0]);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_vec = 0; m_nxt = 0; m_rst = 1;
            return;
        end
        m_vec = 0; m_nxt = 0; m_rst = 0;
        case (m_st)
            0: if (stop_stb) m_st = 2; else if (halt_stb) m_st = 1;
            1: if (host_wr) begin m_st = 0; m_vec = ibf_ie; m_nxt = !ibf_ie; end
            2: if (host_wr) begin m_st = 3; m_cnt = 0; end
            default: begin
                if (m_cnt == N - 1) begin
                    m_st = 0; m_vec = ibf_ie; m_nxt = !ibf_ie;
                end else m_cnt++;
            end
        endcase
    endtask

    // apply inputs for one cycle (called at a falling edge), then check
    task automatic cyc(bit r, bit h, bit s, bit w, bit ie);
        string req;
        req = req_for(m_st, r, h, s, w);
        rst_n = r; halt_stb = h; stop_stb = s; host_wr = w; ibf_ie = ie;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        // R1: state during reset
        n_checks++;
        if ({cpu_clk_en, tmr_clk_en, osc_en, resume_vec, resume_next, restart} !== 6'b111001) begin
            n_fail++;
            $display("FAIL R1: in reset actual=%b expected=111001",
                     {cpu_clk_en, tmr_clk_en, osc_en, resume_vec, resume_next, restart});
        end
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);            // R1: restart drops after first edge
        cyc(1, 0, 0, 1, 1);            // R10
        cyc(1, 1, 0, 0, 0);            // R2
        cyc(1, 1, 1, 0, 0);            // R4 in shallow
        cyc(1, 0, 0, 1, 1);            // R5 vector
        cyc(1, 0, 0, 0, 0);            // R9 pulse ends
        cyc(1, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0);            // R5 next
        cyc(1, 1, 1, 0, 0);            // R3 stop wins
        cyc(1, 1, 1, 0, 0);            // R4 in deep
        cyc(1, 0, 0, 1, 0);            // R6 wake
        for (int i = 0; i < N; i++) cyc(1, 0, 0, (i % 3) == 0, 1); // R7 writes during wait
        cyc(1, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);            // R8 reset mid-wait
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = $urandom_range(0, 99);
            cyc(p != 0, $urandom_range(0, 9) == 0, $urandom_range(0, 19) == 0,
                $urandom_range(0, 6) == 0, $urandom_range(0, 1) == 1);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule